// File: doc/BRIEF.md
# Four-Port Synchronous RAM

This block is a single-clock RAM with four access points: two write ports (A and B) and two read ports (A and B). Writes and reads all happen together on each rising clock edge, so a pipeline can fill and drain the array in the same cycle. Every write port has a write enable per lane. A lane is a group of `LANE_W` bits, so a caller can update part of a word without first reading it back.

Each read port has an address register. The register loads the port's address on a rising edge when the port's read enable is high; otherwise it keeps its old value. The read data register then reloads on every rising edge from the word at the held address. Data for a newly captured address therefore shows up after the following edge. A dedicated asynchronous clear drives both address registers to 0 and leaves the stored words alone. The main reset also zeroes the read data registers.

When a read meets a write to the same word in the same cycle, the two read ports resolve it differently. Port A sees the word as it is after that edge's writes. Port B sees the word as it was before them. The default geometry is 32 words of 20 bits in 2-bit lanes. The parameters reach 512 words of 40 bits.

Top module: `quad_port_ram`

## Requirements
- R1: A write port updates only the lanes whose enable bit is set. Lane l is data bits [l*LANE_W +: LANE_W] and is enabled by bit l of that port's lane-enable input. All other bits of the word keep their value.
- R2: When both write ports are enabled at the same address on one edge, each lane enabled on port A takes port A's data. A lane enabled only on port B takes port B's data.
- R3: A read address register loads its address input on a rising edge when its read enable is high, and otherwise holds. The read data register reloads on every rising edge from the word at the held address, so the data for a new address appears after the edge that follows its capture.
- R4: If write port B writes the word held in read port A's address register, and write port A does not, the value port A loads on that edge is the word with that edge's writes applied.
- R5: If write port A writes the word held in read port B's address register, and write port B does not, the value port B loads on that edge is the word as it stood before that edge.
- R6: A same-port collision leaves the loaded value on that read port unspecified for that cycle. Same-port means write A hitting read A's held address, or write B hitting read B's held address. Even so, the stored word still follows R1 and R2, and later reads return it.
- R7: A high level on `rd_addr_clr` forces both read address registers to 0 at once, without waiting for a clock edge. It blocks any capture while high and changes no stored word.
- R8: A low level on `rst_n` forces both read data outputs and both address registers to 0 at once. Stored words are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every operation happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read registers |
| rd_addr_clr | input | 1 | Asynchronous active-high clear of both read address registers |
| wr_a_en | input | 1 | Write port A enable |
| wr_a_addr | input | ADDR_W | Write port A word address |
| wr_a_be | input | LANES | Write port A lane enables |
| wr_a_data | input | DATA_W | Write port A data |
| wr_b_en | input | 1 | Write port B enable |
| wr_b_addr | input | ADDR_W | Write port B word address |
| wr_b_be | input | LANES | Write port B lane enables |
| wr_b_data | input | DATA_W | Write port B data |
| rd_a_en | input | 1 | Read port A address capture enable |
| rd_a_addr | input | ADDR_W | Read port A address |
| rd_a_data | output | DATA_W | Read port A registered data (sees new data on collision) |
| rd_b_en | input | 1 | Read port B address capture enable |
| rd_b_addr | input | ADDR_W | Read port B address |
| rd_b_data | output | DATA_W | Read port B registered data (sees old data on collision) |

## Verification
The properties assume that `rd_addr_clr`, when it is used, stays high across at least one rising edge. A pulse that falls entirely between two edges would move an address register where no property can see it. The stimulus always holds the clear for a full clock period. The new-data and old-data properties also assume that no same-port write lands on the same word, because that cycle's result is unspecified. The reference model likewise skips comparing a read port in any cycle where its own write port hits its held address. The random phase keeps addresses within a small window so that both kinds of collision occur often.

// File: rtl/qpr_pkg.sv
package qpr_pkg;

   // Number of read access points on the array.
   localparam int RD_PORTS = 2;

   // How a read port resolves a write to its held address in the same cycle.
   typedef enum logic {
      RDW_OLD = 1'b0,
      RDW_NEW = 1'b1
   } rdw_mode_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/qpr_addr_reg.sv
module qpr_addr_reg #(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_q
);

   // Both the reset and the dedicated clear act at once; the clear also
   // blocks a capture for as long as it stays high.
   always_ff @(posedge clk or negedge rst_n or posedge clr) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (clr) begin
         addr_q <= '0;
      end else if (en) begin
         addr_q <= addr_in;
      end
   end

endmodule

// File: rtl/qpr_store.sv
module qpr_store
   import qpr_pkg::*;
#(
   parameter int        DATA_W = 20,
   parameter int        DEPTH  = 32,
   parameter int        LANE_W = 2,
   parameter rdw_mode_e MODE_A = RDW_NEW,
   parameter rdw_mode_e MODE_B = RDW_OLD,
   localparam int       ADDR_W = $clog2(DEPTH),
   localparam int       LANES  = DATA_W / LANE_W
) (
   input  logic                               clk,
   input  logic                               wa_en,
   input  logic [ADDR_W-1:0]                  wa_addr,
   input  logic [LANES-1:0]                   wa_be,
   input  logic [DATA_W-1:0]                  wa_data,
   input  logic                               wb_en,
   input  logic [ADDR_W-1:0]                  wb_addr,
   input  logic [LANES-1:0]                   wb_be,
   input  logic [DATA_W-1:0]                  wb_data,
   input  logic [RD_PORTS-1:0][ADDR_W-1:0]    look_addr,
   output logic [RD_PORTS-1:0][DATA_W-1:0]    word_out
);

   logic [DATA_W-1:0] mem [DEPTH];

   // Port B lanes are written first and port A lanes last, so for any lane
   // both ports enable on one word the later assignment (port A) wins.
   always_ff @(posedge clk) begin
      for (int l = 0; l < LANES; l++) begin
         if (wb_en && wb_be[l]) begin
            mem[wb_addr][l*LANE_W +: LANE_W] <= wb_data[l*LANE_W +: LANE_W];
         end
      end
      for (int l = 0; l < LANES; l++) begin
         if (wa_en && wa_be[l]) begin
            mem[wa_addr][l*LANE_W +: LANE_W] <= wa_data[l*LANE_W +: LANE_W];
         end
      end
   end

   // Each read port picks the variant of its lookup word by its mode.
   for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
      if (((p == 0) ? MODE_A : MODE_B) == RDW_NEW) begin : g_new
         // Forward this edge's writes lane by lane, same priority as above.
         for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic hit_a;
            logic hit_b;
            assign hit_a = wa_en && wa_be[g] && (wa_addr == look_addr[p]);
            assign hit_b = wb_en && wb_be[g] && (wb_addr == look_addr[p]);
            assign word_out[p][g*LANE_W +: LANE_W] =
               hit_a ? wa_data[g*LANE_W +: LANE_W] :
               hit_b ? wb_data[g*LANE_W +: LANE_W] :
                       mem[look_addr[p]][g*LANE_W +: LANE_W];
         end
      end else begin : g_old
         assign word_out[p] = mem[look_addr[p]];
      end
   end

endmodule

// File: rtl/qpr_out_reg.sv
module qpr_out_reg #(
   parameter int DATA_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= d;
      end
   end

endmodule

// File: rtl/quad_port_ram.sv
module quad_port_ram
   import qpr_pkg::*;
#(
   parameter int  DATA_W = 20,
   parameter int  DEPTH  = 32,
   parameter int  LANE_W = 2,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int LANES  = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_addr_clr,
   input  logic              wr_a_en,
   input  logic [ADDR_W-1:0] wr_a_addr,
   input  logic [LANES-1:0]  wr_a_be,
   input  logic [DATA_W-1:0] wr_a_data,
   input  logic              wr_b_en,
   input  logic [ADDR_W-1:0] wr_b_addr,
   input  logic [LANES-1:0]  wr_b_be,
   input  logic [DATA_W-1:0] wr_b_data,
   input  logic              rd_a_en,
   input  logic [ADDR_W-1:0] rd_a_addr,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic              rd_b_en,
   input  logic [ADDR_W-1:0] rd_b_addr,
   output logic [DATA_W-1:0] rd_b_data
);

   // Elaboration-time parameter checks.
   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("quad_port_ram: DATA_W must be a multiple of LANE_W");
   end
   if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("quad_port_ram: DEPTH must be a power of two of at least 2");
   end

   logic [RD_PORTS-1:0]             rd_en_v;
   logic [RD_PORTS-1:0][ADDR_W-1:0] rd_addr_v;
   logic [RD_PORTS-1:0][ADDR_W-1:0] addr_q_v;
   logic [RD_PORTS-1:0][DATA_W-1:0] word_v;
   logic [RD_PORTS-1:0][DATA_W-1:0] data_q_v;
   logic [ADDR_W-1:0]               addr_a_q;
   logic [ADDR_W-1:0]               addr_b_q;

   assign rd_en_v   = {rd_b_en, rd_a_en};
   assign rd_addr_v = {rd_b_addr, rd_a_addr};

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      qpr_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (rd_addr_clr),
         .en      (rd_en_v[p]),
         .addr_in (rd_addr_v[p]),
         .addr_q  (addr_q_v[p])
      );

      qpr_out_reg #(.DATA_W(DATA_W)) u_out (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (word_v[p]),
         .q     (data_q_v[p])
      );
   end

   qpr_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .LANE_W (LANE_W),
      .MODE_A (RDW_NEW),
      .MODE_B (RDW_OLD)
   ) u_store (
      .clk       (clk),
      .wa_en     (wr_a_en),
      .wa_addr   (wr_a_addr),
      .wa_be     (wr_a_be),
      .wa_data   (wr_a_data),
      .wb_en     (wr_b_en),
      .wb_addr   (wr_b_addr),
      .wb_be     (wr_b_be),
      .wb_data   (wr_b_data),
      .look_addr (addr_q_v),
      .word_out  (word_v)
   );

   assign addr_a_q  = addr_q_v[0];
   assign addr_b_q  = addr_q_v[1];
   assign rd_a_data = data_q_v[0];
   assign rd_b_data = data_q_v[1];

endmodule

// File: rtl/qpr_checker.sv
module qpr_checker #(
   parameter int  DATA_W = 20,
   parameter int  DEPTH  = 32,
   parameter int  LANE_W = 2,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int LANES  = DATA_W / LANE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_addr_clr,
   input logic              wr_a_en,
   input logic [ADDR_W-1:0] wr_a_addr,
   input logic              wr_b_en,
   input logic [ADDR_W-1:0] wr_b_addr,
   input logic [LANES-1:0]  wr_b_be,
   input logic [DATA_W-1:0] wr_b_data,
   input logic              rd_a_en,
   input logic [ADDR_W-1:0] rd_a_addr,
   input logic              rd_b_en,
   input logic [ADDR_W-1:0] addr_a_q,
   input logic [ADDR_W-1:0] addr_b_q,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [DATA_W-1:0] rd_b_data
);

   // High when, on the previous edge, port B's held address neither moved
   // nor was written, so port B loaded the same word twice in a row.
   logic b_quiet_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_quiet_q <= 1'b0;
      end else begin
         b_quiet_q <= !(wr_a_en && wr_a_addr == addr_b_q) &&
                      !(wr_b_en && wr_b_addr == addr_b_q) &&
                      !rd_b_en && !rd_addr_clr;
      end
   end

   // R8: outputs held at zero while reset is low.
   p_reset_zero_r8: assert property (@(posedge clk)
      !rst_n |-> (rd_a_data == '0 && rd_b_data == '0));

   // R7: a sampled clear means both address registers already read 0.
   p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr_clr |-> (addr_a_q == '0 && addr_b_q == '0));

   // R3: capture on enable.
   p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_en && !rd_addr_clr) |=> (addr_a_q == $past(rd_a_addr)) || rd_addr_clr);

   // R3: hold without enable.
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_a_en && !rd_addr_clr) |=> $stable(addr_a_q) || rd_addr_clr);

   // R4: a full-word write on port B is seen at once by read port A.
   p_new_on_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_b_en && (&wr_b_be) && wr_b_addr == addr_a_q &&
       !(wr_a_en && wr_a_addr == addr_a_q)) |=> rd_a_data == $past(wr_b_data));

   // R5: a write on port A does not disturb what read port B loads that edge.
   p_old_on_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (b_quiet_q && wr_a_en && wr_a_addr == addr_b_q &&
       !(wr_b_en && wr_b_addr == addr_b_q) && !rd_addr_clr) |=> $stable(rd_b_data));

endmodule

bind quad_port_ram qpr_checker #(
   .DATA_W (DATA_W),
   .DEPTH  (DEPTH),
   .LANE_W (LANE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_addr_clr (rd_addr_clr),
   .wr_a_en     (wr_a_en),
   .wr_a_addr   (wr_a_addr),
   .wr_b_en     (wr_b_en),
   .wr_b_addr   (wr_b_addr),
   .wr_b_be     (wr_b_be),
   .wr_b_data   (wr_b_data),
   .rd_a_en     (rd_a_en),
   .rd_a_addr   (rd_a_addr),
   .rd_b_en     (rd_b_en),
   .addr_a_q    (addr_a_q),
   .addr_b_q    (addr_b_q),
   .rd_a_data   (rd_a_data),
   .rd_b_data   (rd_b_data)
);

// File: tb/quad_port_ram_tb.sv
`timescale 1ns/1ps
module quad_port_ram_tb;

   localparam int DW    = 20;
   localparam int DEPTH = 32;
   localparam int LW    = 2;
   localparam int AW    = $clog2(DEPTH);
   localparam int NL    = DW / LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic          clr = 1'b0;
   logic          wa_en = 1'b0, wb_en = 1'b0, ra_en = 1'b0, rb_en = 1'b0;
   logic [AW-1:0] wa_addr = '0, wb_addr = '0, ra_addr = '0, rb_addr = '0;
   logic [NL-1:0] wa_be = '0, wb_be = '0;
   logic [DW-1:0] wa_d = '0, wb_d = '0;
   logic [DW-1:0] rd_a_data, rd_b_data;

   always #2.5 clk = ~clk;

   quad_port_ram #(.DATA_W(DW), .DEPTH(DEPTH), .LANE_W(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .rd_addr_clr(clr),
      .wr_a_en(wa_en), .wr_a_addr(wa_addr), .wr_a_be(wa_be), .wr_a_data(wa_d),
      .wr_b_en(wb_en), .wr_b_addr(wb_addr), .wr_b_be(wb_be), .wr_b_data(wb_d),
      .rd_a_en(ra_en), .rd_a_addr(ra_addr), .rd_a_data(rd_a_data),
      .rd_b_en(rb_en), .rd_b_addr(rb_addr), .rd_b_data(rd_b_data)
   );

   int    n_chk = 0;
   int    n_err = 0;
   bit    run   = 0;
   bit    done  = 0;
   string cur_tag = "R3";

   task automatic check(input string tag, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   // Behavioural reference model.
   logic [DW-1:0] mm [DEPTH];
   bit            mk [DEPTH];
   int            maq_a = 0, maq_b = 0;
   logic [DW-1:0] exp_a = '0, exp_b = '0;
   bit            ok_a = 1, ok_b = 1;
   string         tag_a = "R8", tag_b = "R8";
   bit            same_a, same_b, cross_a, cross_b;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_a = '0; exp_b = '0; ok_a = 1; ok_b = 1;
         maq_a = 0; maq_b = 0; tag_a = "R8"; tag_b = "R8";
      end else begin
         same_a  = wa_en && (wa_addr == maq_a);
         same_b  = wb_en && (wb_addr == maq_b);
         cross_a = wb_en && (wb_addr == maq_a);
         cross_b = wa_en && (wa_addr == maq_b);
         // Port B: word before this edge.
         exp_b = mm[maq_b];
         ok_b  = mk[maq_b] && !same_b;
         tag_b = (cross_b && !same_b) ? "R5" : cur_tag;
         // Apply writes: B first, A overrides its enabled lanes.
         for (int l = 0; l < NL; l++)
            if (wb_en && wb_be[l]) mm[wb_addr][l*LW +: LW] = wb_d[l*LW +: LW];
         for (int l = 0; l < NL; l++)
            if (wa_en && wa_be[l]) mm[wa_addr][l*LW +: LW] = wa_d[l*LW +: LW];
         if (wb_en && (&wb_be)) mk[wb_addr] = 1;
         if (wa_en && (&wa_be)) mk[wa_addr] = 1;
         // Port A: word after this edge.
         exp_a = mm[maq_a];
         ok_a  = mk[maq_a] && !same_a;
         tag_a = (cross_a && !same_a) ? "R4" : cur_tag;
         if (clr) begin
            maq_a = 0; maq_b = 0;
         end else begin
            if (ra_en) maq_a = ra_addr;
            if (rb_en) maq_b = rb_addr;
         end
      end
   end

   // Compare on every falling edge, well away from the active edge.
   always @(negedge clk) begin
      if (run && rst_n) begin
         if (ok_a) check(tag_a, "read port A", rd_a_data, exp_a);
         if (ok_b) check(tag_b, "read port B", rd_b_data, exp_b);
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      wa_en = 0; wb_en = 0; ra_en = 0; rb_en = 0; clr = 0;
   endtask

   function automatic logic [DW-1:0] pat(input int i);
      return DW'((i * 37 + 5) ^ 'h5A5A5);
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // R8: power-up/reset state.
      #1 rst_n = 0;
      #1;
      check("R8", "reset port A", rd_a_data, '0);
      check("R8", "reset port B", rd_b_data, '0);
      repeat (3) @(negedge clk);
      rst_n = 1;
      run = 1;

      // R3: fill every word with full-lane writes on both ports.
      cur_tag = "R3";
      for (int i = 0; i < DEPTH / 2; i++) begin
         wa_en = 1; wa_addr = AW'(2*i);   wa_be = '1; wa_d = pat(2*i);
         wb_en = 1; wb_addr = AW'(2*i+1); wb_be = '1; wb_d = pat(2*i+1);
         ra_en = 1; ra_addr = AW'(2*i);
         rb_en = 1; rb_addr = AW'(2*i+1);
         tick();
      end
      idle();
      for (int i = 0; i < DEPTH; i++) begin
         ra_en = 1; ra_addr = AW'(i);
         rb_en = 1; rb_addr = AW'(DEPTH - 1 - i);
         tick();
      end
      idle(); tick(); tick();

      // R1: partial lane writes.
      cur_tag = "R1";
      wa_en = 1; wa_addr = 3; wa_be = NL'('b0101010101); wa_d = '1;
      wb_en = 1; wb_addr = 7; wb_be = NL'('b1100000011); wb_d = '0;
      ra_en = 1; ra_addr = 3; rb_en = 1; rb_addr = 7;
      tick();
      idle(); tick(); tick();

      // R2: both write ports on one word, overlapping lanes.
      cur_tag = "R2";
      wa_en = 1; wa_addr = 9; wa_be = NL'('b0000011111); wa_d = DW'('hAAAAA);
      wb_en = 1; wb_addr = 9; wb_be = NL'('b1111111000); wb_d = DW'('h33333);
      ra_en = 1; ra_addr = 9; rb_en = 1; rb_addr = 9;
      tick();
      idle(); tick(); tick();

      // R4 / R5: mixed-port collisions.
      cur_tag = "R3";
      ra_en = 1; ra_addr = 5; rb_en = 1; rb_addr = 6;
      tick();
      idle(); tick();
      wb_en = 1; wb_addr = 5; wb_be = '1; wb_d = DW'('h12345);
      wa_en = 1; wa_addr = 6; wa_be = '1; wa_d = DW'('h6789A);
      tick();
      wb_en = 1; wb_addr = 5; wb_be = NL'('b0000001111); wb_d = DW'('hFFFFF);
      wa_en = 1; wa_addr = 6; wa_be = NL'('b1111000000); wa_d = DW'('h00000);
      tick();
      idle(); tick(); tick();

      // R6: same-port collisions, then read back stored words.
      cur_tag = "R6";
      ra_en = 1; ra_addr = 12; rb_en = 1; rb_addr = 13;
      tick();
      idle();
      wa_en = 1; wa_addr = 12; wa_be = '1; wa_d = DW'('hC0FFE);
      wb_en = 1; wb_addr = 13; wb_be = '1; wb_d = DW'('hBEEF1);
      tick();
      idle(); tick(); tick();

      // R7: asynchronous address clear held across one edge.
      cur_tag = "R7";
      ra_en = 1; ra_addr = 20; rb_en = 1; rb_addr = 21;
      tick();
      idle(); tick();
      clr = 1; maq_a = 0; maq_b = 0;
      ra_en = 1; ra_addr = 22; rb_en = 1; rb_addr = 23;
      tick();
      idle(); tick(); tick();
      ra_en = 1; ra_addr = 20; rb_en = 1; rb_addr = 21;
      tick();
      idle(); tick();

      // R8: mid-run reset clears outputs but keeps stored words.
      cur_tag = "R8";
      rst_n = 0;
      #1;
      check("R8", "mid-run reset port A", rd_a_data, '0);
      check("R8", "mid-run reset port B", rd_b_data, '0);
      @(negedge clk);
      rst_n = 1;
      ra_en = 1; ra_addr = 20; rb_en = 1; rb_addr = 21;
      tick();
      idle(); tick(); tick();

      // R3 with R4/R5 mixed in: random traffic over a narrow window.
      cur_tag = "R3";
      for (int n = 0; n < 3000; n++) begin
         wa_en = 1'($urandom_range(0, 1)); wa_addr = AW'($urandom_range(0, 7));
         wa_be = NL'($urandom); wa_d = DW'($urandom);
         wb_en = 1'($urandom_range(0, 1)); wb_addr = AW'($urandom_range(0, 7));
         wb_be = NL'($urandom); wb_d = DW'($urandom);
         ra_en = 1'($urandom_range(0, 1)); ra_addr = AW'($urandom_range(0, 7));
         rb_en = 1'($urandom_range(0, 1)); rb_addr = AW'($urandom_range(0, 7));
         if (($urandom_range(0, 15) == 0)) begin
            wa_be = '1; wb_be = '1;
         end
         tick();
      end
      idle(); tick(); tick();
      finish_run();
   end

endmodule